// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial bus target that gives an external controller read and write access to an array of 256 eight-bit configuration registers. The block runs on a fast system clock. It oversamples the serial clock and data lines through synchronizers and detects their edges. It drives the data line only through an open-drain pull-low enable. It recognizes one fixed 7-bit bus address, 0x69. It accepts single-byte and burst writes, and it serves three kinds of read: current-address, random and sequential.

A register pointer stays valid from one transaction to the next. Every stored or transmitted byte moves the pointer forward by one, and it wraps from 0xFF to 0x00. A read that has no address phase therefore returns the location after the last one accessed. For a random read, the controller writes a register address and then issues a repeated START before any data byte. The pointer is loaded, nothing is stored, and the read that follows starts at that address. The configuration logic reads any register at any time through a separate combinational port.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, register k holds k XOR DEFAULT_SEED (0x5A by default), the pointer is 0x00 and the data line is released.
- R2: The first byte after a START is taken as the address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When bits 7..1 equal 0x69, the target pulls the data line low during the 9th clock.
- R3: When the address does not match, the target does not acknowledge and ignores the bus until the next START or STOP. No register and no pointer value changes.
- R4: In a write, the byte after the address is loaded into the pointer. The next byte is stored at that location, and every received byte is acknowledged.
- R5: Each further byte of a write goes to the next location, until a STOP. The location after 0xFF is 0x00.
- R6: A read with no preceding address phase returns the register at the pointer, which is one past the last location read or written.
- R7: When a register-address phase is ended by a repeated START, nothing is stored, and the read that follows starts at the loaded address.
- R8: In a read, each transmitted byte advances the pointer, wrapping 0xFF to 0x00. A controller acknowledge (data low on the 9th clock) makes the target send the next byte. A not-acknowledge makes the target release the line until the next START or STOP.
- R9: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. Either one abandons the current transfer, and a partly received byte is never stored.
- R10: The target only ever pulls the data line low, and it begins a pull only while the clock line is low.
- R11: The configuration read port returns the register selected by the port's address input, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaDriveLow | output | 1 | When high, the pad pulls the data line low; otherwise it is released |
| cfgRdAddr | input | 8 | Register index for the configuration read port |
| cfgRdData | output | 8 | Contents of the register at cfgRdAddr |

## Verification
The assertions check on every cycle that the pointer steps by exactly one, with wrap, whenever a byte completes. They also check that a stored byte lands at the pointer value from before the increment, that START and STOP force the control state, that the line is never pulled while the target is ignoring the bus, and that a pull only starts while the clock is low. Bus-level protocol outcomes can only be shown by the bench's transactions: acknowledge or its absence, persistence of the pointer between transactions, random reads through a repeated START, a long sequential read across the 0xFF to 0x00 boundary, and an abandoned partial byte. The bench also sweeps all 256 reset values through the configuration port.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NREG = 1 << ADDR_W;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic              wrEn;     // store data at pointer, then advance
    logic              ptrLoad;  // load pointer with data
    logic              ptrInc;   // advance pointer by one
    logic [DATA_W-1:0] data;
  } regStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD,
    ST_SKIP
  } busStateT;
endpackage

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEFAULT_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strobe,
  output logic [DATA_W-1:0] ptrData,
  input  logic [ADDR_W-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData
);
  logic [DATA_W-1:0] regs [NREG];
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= DATA_W'(i) ^ DEFAULT_SEED;
    end else if (strobe.wrEn) begin
      regs[ptr] <= strobe.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= '0;
    else if (strobe.ptrLoad) ptr <= strobe.data[ADDR_W-1:0];
    else if (strobe.ptrInc)  ptr <= ptr + 1'b1;
  end

  assign ptrData   = regs[ptr];
  assign cfgRdData = regs[cfgRdAddr];

  // R5 / R8: pointer advances by one with natural wrap
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ptrInc && !strobe.ptrLoad) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R4: a stored byte lands at the pre-increment pointer
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> regs[$past(ptr)] == $past(strobe.data));
endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] ptrData,
  output regStrobeT         strobe,
  output logic              sdaDriveLow
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startEv = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv  = sclS & sclQ & ~sdaQ & sdaS;

  busStateT          state;
  logic [CNT_W-1:0]  bitCnt;
  logic              inAck, drvLow, isRead;
  logic [DATA_W-1:0] shiftIn, txShift;
  logic              byteEnd;

  assign byteEnd = sclFall && !inAck && (bitCnt == BYTE_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      drvLow  <= 1'b0;
      isRead  <= 1'b0;
      shiftIn <= '0;
      txShift <= '0;
    end else if (startEv || stopEv) begin
      state  <= startEv ? ST_DEV : ST_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
      drvLow <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (sclRise && !inAck) begin
            shiftIn <= {shiftIn[DATA_W-2:0], sdaS};
            bitCnt  <= bitCnt + 1'b1;
          end else if (byteEnd) begin
            if (state == ST_DEV && shiftIn[DATA_W-1:1] != DEV_ADDR) begin
              state <= ST_SKIP;
            end else begin
              inAck  <= 1'b1;
              drvLow <= 1'b1;
              if (state == ST_DEV) isRead <= shiftIn[0];
            end
          end else if (sclFall && inAck) begin
            inAck  <= 1'b0;
            bitCnt <= '0;
            drvLow <= 1'b0;
            if (state == ST_DEV) begin
              if (isRead) begin
                state   <= ST_RD;
                txShift <= ptrData;
                drvLow  <= ~ptrData[DATA_W-1];
              end else begin
                state <= ST_REG;
              end
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (!inAck) begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == BYTE_DONE) begin
                drvLow <= 1'b0;
                inAck  <= 1'b1;
              end else begin
                txShift <= {txShift[DATA_W-2:0], 1'b0};
                drvLow  <= ~txShift[DATA_W-2];
              end
            end
          end else begin
            if (sclRise && sdaS) begin
              state <= ST_SKIP;
            end else if (sclFall) begin
              inAck   <= 1'b0;
              bitCnt  <= '0;
              txShift <= ptrData;
              drvLow  <= ~ptrData[DATA_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.data    = shiftIn;
    strobe.wrEn    = (state == ST_WR) && byteEnd && !startEv && !stopEv;
    strobe.ptrLoad = (state == ST_REG) && byteEnd && !startEv && !stopEv;
    strobe.ptrInc  = strobe.wrEn ||
                     ((state == ST_RD) && inAck && sclRise && !startEv && !stopEv);
  end

  assign sdaDriveLow = drvLow;

  // R9: START and STOP take over the control state
  assert_start_enters_dev_R9: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> state == ST_DEV);
  assert_stop_goes_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !startEv) |=> state == ST_IDLE);
  // R10: a pull-low only begins while the clock is low
  assert_pull_on_low_clock_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvLow) |-> !sclS);
  // R3 / R8: the line is released while the bus is ignored
  assert_skip_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP || state == ST_IDLE) |-> !drvLow);
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR     = 7'h69,
  parameter logic [DATA_W-1:0] DEFAULT_SEED = 8'h5A,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [ADDR_W-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData
);
  regStrobeT         strobe;
  logic [DATA_W-1:0] ptrData;

  i2c_cfg_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .ptrData    (ptrData),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_cfg_regs #(
    .DEFAULT_SEED(DEFAULT_SEED)
  ) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ptrData  (ptrData),
    .cfgRdAddr(cfgRdAddr),
    .cfgRdData(cfgRdData)
  );
endmodule

// File: tb/tb_i2c_cfg_target.sv
module tb_i2c_cfg_target;
  localparam logic [7:0] SEED  = 8'h5A;
  localparam logic [7:0] WADDR = 8'hD2;  // 0x69 << 1 | write
  localparam logic [7:0] RADDR = 8'hD3;  // 0x69 << 1 | read
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic tbPull = 1'b0;
  logic sdaDriveLow;
  logic [7:0] cfgRdAddr = 8'h00;
  logic [7:0] cfgRdData;
  logic sdaBus;

  assign sdaBus = ~(tbPull | sdaDriveLow);

  always #5 clk = ~clk;

  i2c_cfg_target #(.DEFAULT_SEED(SEED)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclLine),
    .sdaIn      (sdaBus),
    .sdaDriveLow(sdaDriveLow),
    .cfgRdAddr  (cfgRdAddr),
    .cfgRdData  (cfgRdData)
  );

  int checks = 0;
  int errors = 0;
  int pullViol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr;
  logic prevDrv = 1'b0;

  // R10: the target must not begin a pull while the clock line is high
  always @(posedge clk) begin
    if (rstN && sdaDriveLow && !prevDrv && sclLine) pullViol++;
    prevDrv <= sdaDriveLow;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putBit(input bit b);
    waitC(2); tbPull = !b; waitC(HALF - 2);
    sclLine = 1'b1; waitC(HALF); sclLine = 1'b0;
  endtask

  task automatic getBit(output bit b);
    waitC(2); tbPull = 1'b0; waitC(HALF - 2);
    sclLine = 1'b1; waitC(HALF / 2); b = sdaBus; waitC(HALF / 2); sclLine = 1'b0;
  endtask

  task automatic busStart();
    if (!sclLine) begin
      waitC(2); tbPull = 1'b0; waitC(HALF - 2); sclLine = 1'b1; waitC(HALF);
    end
    tbPull = 1'b1; waitC(HALF); sclLine = 1'b0;
  endtask

  task automatic busStop();
    waitC(2); tbPull = 1'b1; waitC(HALF - 2); sclLine = 1'b1; waitC(HALF);
    tbPull = 1'b0; waitC(HALF);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(s);
    acked = !s;
  endtask

  task automatic recvByte(input bit lastByte, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin getBit(s); v[i] = s; end
    putBit(lastByte);
  endtask

  task automatic currentRead(input string tag);
    bit a; logic [7:0] v;
    busStart(); sendByte(RADDR, a);
    check(a, {tag, " addr ack"}, a, 1);
    recvByte(1'b1, v);
    check(v == model[mptr], tag, v, model[mptr]);
    mptr = mptr + 1'b1;
    busStop();
  endtask

  task automatic writeBurst(input logic [7:0] start, input int n, input logic [7:0] base);
    bit a;
    busStart(); sendByte(WADDR, a);
    check(a, "R2 write address ack", a, 1);
    sendByte(start, a);
    check(a, "R4 register address ack", a, 1);
    mptr = start;
    for (int i = 0; i < n; i++) begin
      sendByte(base + 8'(i * 7), a);
      check(a, "R5 data ack", a, 1);
      model[mptr] = base + 8'(i * 7);
      mptr = mptr + 1'b1;
    end
    busStop();
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ SEED;
    mptr = 8'h00;
    waitC(5); rstN = 1'b1; waitC(5);

    // R1 / R11: reset contents swept through the configuration port
    check(sdaBus == 1'b1, "R1 line released", sdaBus, 1);
    for (int i = 0; i < 256; i++) begin
      cfgRdAddr = 8'(i); #1;
      check(cfgRdData == (8'(i) ^ SEED), "R1 R11 reset value", cfgRdData, 8'(i) ^ SEED);
    end

    // R6: bare read after reset starts at 0x00
    currentRead("R6 read after reset");

    // R4: single-byte write
    writeBurst(8'h10, 1, 8'h3C);
    cfgRdAddr = 8'h10; #1;
    check(cfgRdData == 8'h3C, "R4 single write", cfgRdData, 8'h3C);
    currentRead("R6 read after write");

    // R5: burst write wrapping 0xFF -> 0x00
    writeBurst(8'hFE, 4, 8'hA1);
    for (int i = 0; i < 4; i++) begin
      cfgRdAddr = 8'hFE + 8'(i); #1;
      check(cfgRdData == model[cfgRdAddr], "R5 burst wrap", cfgRdData, model[cfgRdAddr]);
    end
    currentRead("R6 read after burst");

    // R7: random read through repeated START
    busStart(); sendByte(WADDR, a); sendByte(8'h40, a);
    busStart(); sendByte(RADDR, a);
    check(a, "R7 read address ack", a, 1);
    recvByte(1'b1, v);
    check(v == model[8'h40], "R7 random read", v, model[8'h40]);
    busStop();
    cfgRdAddr = 8'h40; #1;
    check(cfgRdData == model[8'h40], "R7 nothing stored", cfgRdData, model[8'h40]);
    mptr = 8'h41;

    // R8: sequential read of 64 bytes across the wrap
    busStart(); sendByte(WADDR, a); sendByte(8'hE0, a);
    busStart(); sendByte(RADDR, a);
    mptr = 8'hE0;
    for (int i = 0; i < 64; i++) begin
      recvByte(i == 63, v);
      check(v == model[mptr], "R8 sequential byte", v, model[mptr]);
      mptr = mptr + 1'b1;
    end
    waitC(HALF);
    check(sdaBus == 1'b1 && !sdaDriveLow, "R8 released after nack", sdaBus, 1);
    busStop();
    currentRead("R8 pointer after sequential");

    // R3: wrong address ignored, including trailing bytes
    busStart(); sendByte(8'hD0, a);
    check(!a, "R3 no ack on mismatch", a, 0);
    sendByte(8'h50, a);
    check(!a, "R3 ignored byte", a, 0);
    sendByte(8'hEE, a);
    check(!a, "R3 ignored data", a, 0);
    busStop();
    cfgRdAddr = 8'h50; #1;
    check(cfgRdData == model[8'h50], "R3 register unchanged", cfgRdData, model[8'h50]);
    currentRead("R3 pointer unchanged");

    // R9: STOP in the middle of a data byte stores nothing
    busStart(); sendByte(WADDR, a); sendByte(8'h60, a);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStop();
    cfgRdAddr = 8'h60; #1;
    check(cfgRdData == model[8'h60], "R9 partial byte dropped", cfgRdData, model[8'h60]);
    mptr = 8'h60;
    currentRead("R9 pointer loaded before abort");

    check(pullViol == 0, "R10 pull begins on low clock", pullViol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule